// File: doc/BRIEF.md
# Interrupt status and enable unit

This block keeps the interrupt state of an adapter: a small status register whose bits are raised by internal completion and message events, and a 32-bit enable register written by software. An interrupt is pending whenever any status bit is set together with the matching enable bit. Depending on a mode input, the pending condition either drives a level-sensitive interrupt line or produces single-cycle message pulses for a message-signalled interrupt path.

Software reads both registers through a read port and clears status bits by writing ones to the status offset. Each status write also produces a one-cycle strobe. Upstream completion logic uses that strobe to try again to deliver completions that are still queued. An adapter reset input wipes the status register. The output stage is registered, so a change of state shows at the outputs one cycle after the register update that caused it.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, status reads 0, enable reads 0, and irq_level, msi_pulse and status_cleared are all 0.
- R2: A cycle with cmpl_evt high sets status bit 0, and a cycle with msg_evt high sets status bit 1. Both are read at offset 0x00, with bits 31..2 reading zero.
- R3: A write to offset 0x00 clears exactly the status bits whose data bits are one. An event that arrives in the same cycle as a clear of the same bit leaves that bit set.
- R4: A write to offset 0x04 replaces all 32 bits of the enable register, which reads back at offset 0x04.
- R5: A read of any offset other than 0x00 and 0x04 returns zero, and a write to such an offset changes neither register.
- R6: With msi_mode = 0, irq_level equals the OR of (status AND enable). It is updated in the cycle after any event, status write, enable write or adapter reset.
- R7: With msi_mode = 1, msi_pulse is high for one cycle, one cycle after an update that leaves the condition true. No pulse follows an update that leaves it false, and irq_level is held at 0.
- R8: status_cleared is high for exactly one cycle, one cycle after every write to offset 0x00, including a write of all zeros.
- R9: adapter_reset clears the status register even when an event arrives in the same cycle. It leaves the enable register unchanged and counts as an update for R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cmpl_evt | input | 1 | Completion event, sets status bit 0 |
| msg_evt | input | 1 | Message event, sets status bit 1 |
| adapter_reset | input | 1 | Clears the status register |
| msi_mode | input | 1 | 1 selects pulse delivery, 0 selects the level line |
| irq_level | output | 1 | Level-sensitive interrupt line |
| msi_pulse | output | 1 | One-cycle message interrupt pulse |
| status_cleared | output | 1 | One-cycle strobe after a status write |

## Verification
The condition logic is tested with enable patterns that select only the completion bit, only the message bit, both bits, and only unused upper bits. This separates a correct per-bit AND from a plain OR of the status bits. Clears are tested with single-bit data, zero data and all-ones data, and one clear coincides with an event on the same bit to show that the set wins. Identical stimulus is applied in both modes to confirm that only the level changes in legacy mode and only the pulse changes in message mode. A zero-data status write in message mode must give both the strobe and a fresh pulse. An adapter reset that coincides with an event must still leave status at zero.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned STAT_W   = 2;
  localparam int unsigned CMPL_BIT = 0;
  localparam int unsigned MSG_BIT  = 1;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic              wipe,
  output logic [STAT_W-1:0] status_q
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = wipe | set_vec[b] | (clr_en & clr_bits[b]);
      if (wipe)            bit_d = 1'b0;
      else if (set_vec[b]) bit_d = 1'b1;
      else                 bit_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status_q[b] <= 1'b0;
      else if (bit_en) status_q[b] <= bit_d;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] mask_q
);
  logic [DATA_W-1:0] mask_d;

  always_comb mask_d = load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              msi_mode,
  input  logic [DATA_W-1:0] status_ext,
  input  logic [DATA_W-1:0] mask,
  output logic              irq_level,
  output logic              msi_pulse
);
  logic cond;
  logic level_d, pulse_d;

  always_comb begin
    cond    = |(status_ext & mask);
    level_d = irq_level;
    if (upd) level_d = cond & ~msi_mode;
    pulse_d = upd & msi_mode & cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= 1'b0;
      msi_pulse <= 1'b0;
    end else begin
      irq_level <= level_d;
      msi_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OFF_STATUS = 'h00,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmpl_evt,
  input  logic              msg_evt,
  input  logic              adapter_reset,
  input  logic              msi_mode,
  output logic              irq_level,
  output logic              msi_pulse,
  output logic              status_cleared
);
  localparam int unsigned PAD_W = DATA_W - STAT_W;

  logic              rst_sync_n;
  logic              st_wr, mk_wr, upd_d, upd_q, strobe_d;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] status_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_ext;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    st_wr             = wr_en && (wr_addr == OFF_STATUS);
    mk_wr             = wr_en && (wr_addr == OFF_MASK);
    set_vec           = '0;
    set_vec[CMPL_BIT] = cmpl_evt;
    set_vec[MSG_BIT]  = msg_evt;
    upd_d             = st_wr | mk_wr | cmpl_evt | msg_evt | adapter_reset;
    strobe_d          = st_wr;
    status_ext        = {{PAD_W{1'b0}}, status_q};
  end

  irq_status_reg u_status (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec), .clr_en(st_wr),
    .clr_bits(wr_data[STAT_W-1:0]), .wipe(adapter_reset), .status_q(status_q)
  );

  irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_sync_n), .load(mk_wr), .load_data(wr_data), .mask_q(mask_q)
  );

  irq_deliver #(.DATA_W(DATA_W)) u_deliver (
    .clk(clk), .rst_n(rst_sync_n), .upd(upd_q), .msi_mode(msi_mode),
    .status_ext(status_ext), .mask(mask_q),
    .irq_level(irq_level), .msi_pulse(msi_pulse)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upd_q          <= 1'b0;
      status_cleared <= 1'b0;
    end else begin
      upd_q          <= upd_d;
      status_cleared <= strobe_d;
    end
  end

  always_comb begin
    if (rd_addr == OFF_STATUS)    rd_data = status_ext;
    else if (rd_addr == OFF_MASK) rd_data = mask_q;
    else                          rd_data = '0;
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_STATUS = 'h00,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 'h04
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              cmpl_evt,
  input logic              msg_evt,
  input logic              adapter_reset,
  input logic              msi_mode,
  input logic              irq_level,
  input logic              msi_pulse,
  input logic              status_cleared,
  input logic [STAT_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              upd_q
);
  logic chk_cond, st_w, mk_w;
  assign chk_cond = |(status_q & mask_q[STAT_W-1:0]);
  assign st_w     = wr_en && (wr_addr == OFF_STATUS);
  assign mk_w     = wr_en && (wr_addr == OFF_MASK);

  p_cmpl_sets_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmpl_evt && !adapter_reset) |=> status_q[CMPL_BIT]);
  p_msg_sets_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msg_evt && !adapter_reset) |=> status_q[MSG_BIT]);
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_w && !cmpl_evt && !msg_evt && !adapter_reset) |=>
      (status_q == ($past(status_q) & ~$past(wr_data[STAT_W-1:0]))));
  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mk_w |=> (mask_q == $past(wr_data)));
  p_unknown_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_addr != OFF_STATUS && rd_addr != OFF_MASK) |-> (rd_data == '0));
  p_level_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_q && !msi_mode) |=> (irq_level == $past(chk_cond)));
  p_pulse_no_level_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msi_pulse |-> !irq_level);
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msi_pulse |-> $past(upd_q && msi_mode));
  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    st_w |=> status_cleared);
  p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adapter_reset |=> (status_q == '0));
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_STATUS(OFF_STATUS), .OFF_MASK(OFF_MASK)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cmpl_evt(cmpl_evt),
  .msg_evt(msg_evt), .adapter_reset(adapter_reset), .msi_mode(msi_mode),
  .irq_level(irq_level), .msi_pulse(msi_pulse), .status_cleared(status_cleared),
  .status_q(status_q), .mask_q(mask_q), .upd_q(upd_q)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cmpl_evt = 1'b0, msg_evt = 1'b0, adapter_reset = 1'b0, msi_mode = 1'b0;
  logic        irq_level, msi_pulse, status_cleared;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] st_s, mk_s;
  logic        sc_s, lv_s, pl_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmpl_evt(cmpl_evt), .msg_evt(msg_evt),
    .adapter_reset(adapter_reset), .msi_mode(msi_mode), .irq_level(irq_level),
    .msi_pulse(msi_pulse), .status_cleared(status_cleared)
  );

  typedef struct packed {
    logic        mode;
    logic        cmpl;
    logic        msg;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp_st;
    logic [31:0] exp_mk;
    logic        exp_lv;
    logic        exp_pl;
    logic        exp_sc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,8'h04,32'h0000_0001,32'h0,32'h0000_0001,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h00,32'h0,        32'h1,32'h0000_0001,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,8'h00,32'h0,        32'h3,32'h0000_0001,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,32'h0000_0001,32'h2,32'h0000_0001,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,8'h04,32'h0000_0002,32'h2,32'h0000_0002,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h04,32'hFFFF_0000,32'h2,32'hFFFF_0000,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,8'h04,32'h0000_0003,32'h2,32'h0000_0003,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,8'h00,32'h0000_0002,32'h0,32'h0000_0003,1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,8'h00,32'h0,        32'h1,32'h0000_0003,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,8'h00,32'h0,        32'h1,32'h0000_0003,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,8'h04,32'h0,        32'h1,32'h0,        1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,8'h00,32'h0,        32'h3,32'h0,        1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,32'hFFFF_FFFF,32'h0,32'h0,        1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,8'h08,32'h0000_00FF,32'h0,32'h0,        1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic op(input logic m, input logic c, input logic g, input logic w,
                    input logic r, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    msi_mode = m; cmpl_evt = c; msg_evt = g; wr_en = w; adapter_reset = r;
    wr_addr = a; wr_data = d;
    @(negedge clk);
    cmpl_evt = 0; msg_evt = 0; wr_en = 0; adapter_reset = 0;
    sc_s = status_cleared;
    rd(8'h00, st_s);
    rd(8'h04, mk_s);
    @(negedge clk);
    lv_s = irq_level;
    pl_s = msi_pulse;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(8'h00, v); chk("R1 status after reset", v, 32'h0);
    rd(8'h04, v); chk("R1 enable after reset", v, 32'h0);
    chk("R1 irq_level after reset", {31'b0, irq_level}, 32'h0);
    chk("R1 msi_pulse after reset", {31'b0, msi_pulse}, 32'h0);
    chk("R1 status_cleared after reset", {31'b0, status_cleared}, 32'h0);

    // Vector walk covering R2, R3, R4, R5, R6, R7 and R8
    for (int i = 0; i < NV; i++) begin
      op(VEC[i].mode, VEC[i].cmpl, VEC[i].msg, VEC[i].wr, 1'b0, VEC[i].addr, VEC[i].data);
      chk($sformatf("R2/R3 status vec %0d", i), st_s, VEC[i].exp_st);
      chk($sformatf("R4 enable vec %0d", i), mk_s, VEC[i].exp_mk);
      chk($sformatf("R6 level vec %0d", i), {31'b0, lv_s}, {31'b0, VEC[i].exp_lv});
      chk($sformatf("R7 pulse vec %0d", i), {31'b0, pl_s}, {31'b0, VEC[i].exp_pl});
      chk($sformatf("R8 strobe vec %0d", i), {31'b0, sc_s}, {31'b0, VEC[i].exp_sc});
      @(negedge clk);
      chk($sformatf("R7 pulse width vec %0d", i), {31'b0, msi_pulse}, 32'h0);
      chk($sformatf("R8 strobe width vec %0d", i), {31'b0, status_cleared}, 32'h0);
    end

    // R6 latency: level unchanged one cycle after the event, set the cycle after
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04, 32'h1);
    @(negedge clk);
    cmpl_evt = 1;
    @(negedge clk);
    cmpl_evt = 0;
    chk("R6 level not yet", {31'b0, irq_level}, 32'h0);
    @(negedge clk);
    chk("R6 level after one cycle", {31'b0, irq_level}, 32'h1);

    // R3 set wins over a same-cycle clear of the same bit
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 32'h1);
    chk("R3 clear before race", st_s, 32'h0);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 32'h1);
    chk("R3 set wins race", st_s, 32'h1);
    chk("R8 strobe on race write", {31'b0, sc_s}, 32'h1);

    // R9 adapter reset with a coincident event
    op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 32'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04, 32'h3);
    chk("R9 precondition level", {31'b0, lv_s}, 32'h1);
    op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 32'h0);
    chk("R9 status wiped", st_s, 32'h0);
    chk("R9 enable kept", mk_s, 32'h3);
    chk("R9 level dropped", {31'b0, lv_s}, 32'h0);

    // R5 unknown offsets read zero with both registers nonzero
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R5 read 0x08", v, 32'h0);
    rd(8'h0C, v); chk("R5 read 0x0C", v, 32'h0);
    rd(8'hFF, v); chk("R5 read 0xFF", v, 32'h0);
    rd(8'h04, v); chk("R4 read enable all ones", v, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 read status bit0", v, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule